// File: doc/BRIEF.md
# Float to Unsigned Truncating Converter

This block turns a single-precision IEEE-754 operand into an unsigned integer, always discarding the fractional part (rounding toward zero), no matter which rounding mode the rest of the floating-point unit is set to. A start strobe samples the operand. One clock later a valid pulse presents the integer together with a small exception vector, which a separate status-flag unit folds into its sticky flags.

Special inputs follow fixed rules. Any NaN gives zero. Any value strictly below zero gives zero, and that includes tiny negative fractions and negative denormals. Positive infinity, and positive values too large for the output width, saturate to all ones. Each of these raises the invalid exception. Whenever invalid is raised, inexact is held low. A conversion with no exception drives an all-zero vector, so the flag unit can clear its summary bit.

The operand split, the output width and the shift network are parameters. The default is binary32 to 32 bits.

Top module: `flt2uns_trunc`

## Requirements
- R1: `valid_o` is high in the cycle after a cycle with `start_i` high, and low otherwise. `result_o` and `exc_o` change only on a start and hold their value between starts.
- R2: While `rst_n` is low, `valid_o`, `result_o` and `exc_o` are all zero.
- R3: A NaN operand (exponent all ones, fraction non-zero, either sign, quiet or signaling) gives result 0 and `exc_o` = 2'b01. Bit 0 is invalid and bit 1 is inexact.
- R4: A non-NaN operand with the sign bit set and a non-zero magnitude gives result 0 and `exc_o` = 2'b01. This covers -0.5, negative denormals and negative infinity.
- R5: +0.0 and -0.0 give result 0 and `exc_o` = 2'b00.
- R6: Positive infinity, and positive finite values of 2^32 or more, give 0xFFFFFFFF and `exc_o` = 2'b01.
- R7: A positive normal value from 1.0 up to but not including 2^32 gives its integer part, truncated toward zero. `exc_o` is 2'b10 if a non-zero fraction was dropped, and 2'b00 otherwise.
- R8: A positive denormal, or a positive normal value below 1.0, gives result 0 and `exc_o` = 2'b10.
- R9: `exc_o` never shows invalid and inexact together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Samples `op_i` for a conversion |
| op_i | input | 32 | Floating-point operand (sign, exponent, fraction) |
| valid_o | output | 1 | One-cycle pulse marking a finished conversion |
| result_o | output | 32 | Unsigned integer result |
| exc_o | output | 2 | Exceptions: bit 0 invalid, bit 1 inexact |

## Verification
The main sweep runs every biased exponent with both signs and a set of fraction patterns: zero, the lowest bit alone, the top bit alone, all ones, and two alternating patterns. The empty fraction separates zeros and infinities from NaNs and denormals. The lowest-bit and alternating patterns show whether truncation drops exactly the right bits and sets inexact only when a set bit is lost. The exponents around the unit value and around 2^32 separate R8 from R7 and R7 from R6. Single directed cases cover -0.5, 2^32, the largest exact value below it, back-to-back starts and holding of the result while idle.

// File: rtl/flt2uns_pkg.sv
package flt2uns_pkg;
   typedef enum logic [2:0] {
      CLS_ZERO,
      CLS_SUB,
      CLS_NORM,
      CLS_INF,
      CLS_NAN
   } fcls_e;

   localparam int EXC_W   = 2;
   localparam int EXC_INV = 0;
   localparam int EXC_INX = 1;
endpackage

// File: rtl/flt2uns_unpack.sv
module flt2uns_unpack
   import flt2uns_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FLT_W = 1 + EXP_W + MAN_W
) (
   input  logic [FLT_W-1:0] op_i,
   output logic             sign_o,
   output fcls_e            cls_o,
   output logic [EXP_W-1:0] exp_o,
   output logic [MAN_W:0]   sig_o
);
   logic [MAN_W-1:0] frac;
   logic             exp_max;
   logic             exp_min;
   logic             frac_nz;

   assign sign_o  = op_i[FLT_W-1];
   assign exp_o   = op_i[FLT_W-2 -: EXP_W];
   assign frac    = op_i[MAN_W-1:0];
   assign exp_max = &exp_o;
   assign exp_min = ~|exp_o;
   assign frac_nz = |frac;
   assign sig_o   = {~exp_min, frac};

   always_comb begin
      if (exp_max)      cls_o = frac_nz ? CLS_NAN : CLS_INF;
      else if (exp_min) cls_o = frac_nz ? CLS_SUB : CLS_ZERO;
      else              cls_o = CLS_NORM;
   end
endmodule

// File: rtl/flt2uns_shift.sv
module flt2uns_shift #(
   parameter int MAN_W = 23,
   parameter int OUT_W = 32,
   localparam int SH_W   = $clog2(OUT_W),
   localparam int WIDE_W = MAN_W + OUT_W
) (
   input  logic [MAN_W:0]   sig_i,
   input  logic [SH_W-1:0]  amt_i,
   output logic [OUT_W-1:0] int_o,
   output logic             frac_nz_o
);
   logic [WIDE_W-1:0] stg [0:SH_W];

   assign stg[0] = WIDE_W'(sig_i);

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
   end

   assign int_o     = stg[SH_W][MAN_W +: OUT_W];
   assign frac_nz_o = |stg[SH_W][MAN_W-1:0];
endmodule

// File: rtl/flt2uns_decide.sv
module flt2uns_decide
   import flt2uns_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int OUT_W = 32,
   localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
   input  logic             sign_i,
   input  fcls_e            cls_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic [OUT_W-1:0] int_i,
   input  logic             frac_nz_i,
   output logic [OUT_W-1:0] res_o,
   output logic [EXC_W-1:0] exc_o
);
   always_comb begin
      res_o = '0;
      exc_o = '0;
      if (cls_i == CLS_NAN) begin
         exc_o[EXC_INV] = 1'b1;
      end else if (sign_i) begin
         if (cls_i != CLS_ZERO) exc_o[EXC_INV] = 1'b1;
      end else begin
         case (cls_i)
            CLS_INF: begin
               res_o          = '1;
               exc_o[EXC_INV] = 1'b1;
            end
            CLS_SUB: exc_o[EXC_INX] = 1'b1;
            CLS_NORM: begin
               if (int'(exp_i) < BIAS) begin
                  exc_o[EXC_INX] = 1'b1;
               end else if (int'(exp_i) >= BIAS + OUT_W) begin
                  res_o          = '1;
                  exc_o[EXC_INV] = 1'b1;
               end else begin
                  res_o          = int_i;
                  exc_o[EXC_INX] = frac_nz_i;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flt2uns_trunc.sv
module flt2uns_trunc
   import flt2uns_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int OUT_W = 32,
   localparam int FLT_W = 1 + EXP_W + MAN_W,
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
   localparam int SH_W  = $clog2(OUT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [FLT_W-1:0] op_i,
   output logic             valid_o,
   output logic [OUT_W-1:0] result_o,
   output logic [EXC_W-1:0] exc_o
);
   if (EXP_W < 2 || EXP_W > 15) begin : g_bad_exp
      $error("flt2uns_trunc: EXP_W out of range");
   end
   if (MAN_W < 1) begin : g_bad_man
      $error("flt2uns_trunc: MAN_W must be positive");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("flt2uns_trunc: OUT_W too small");
   end
   if (BIAS + OUT_W > (1 << EXP_W) - 1) begin : g_bad_range
      $error("flt2uns_trunc: exponent cannot reach saturation range");
   end

   logic             sign_w;
   fcls_e            cls_w;
   logic [EXP_W-1:0] exp_w;
   logic [MAN_W:0]   sig_w;
   logic [SH_W-1:0]  shamt;
   logic [OUT_W-1:0] int_w;
   logic             frac_nz_w;
   logic [OUT_W-1:0] res_w;
   logic [EXC_W-1:0] exc_w;

   flt2uns_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .op_i   (op_i),
      .sign_o (sign_w),
      .cls_o  (cls_w),
      .exp_o  (exp_w),
      .sig_o  (sig_w)
   );

   assign shamt = SH_W'(exp_w - EXP_W'(BIAS));

   flt2uns_shift #(.MAN_W(MAN_W), .OUT_W(OUT_W)) u_shift (
      .sig_i     (sig_w),
      .amt_i     (shamt),
      .int_o     (int_w),
      .frac_nz_o (frac_nz_w)
   );

   flt2uns_decide #(.EXP_W(EXP_W), .OUT_W(OUT_W)) u_decide (
      .sign_i    (sign_w),
      .cls_i     (cls_w),
      .exp_i     (exp_w),
      .int_i     (int_w),
      .frac_nz_i (frac_nz_w),
      .res_o     (res_w),
      .exc_o     (exc_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         result_o <= '0;
         exc_o    <= '0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            result_o <= res_w;
            exc_o    <= exc_w;
         end
      end
   end
endmodule

// File: rtl/flt2uns_trunc_chk.sv
module flt2uns_trunc_chk #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int OUT_W = 32,
   localparam int FLT_W = 1 + EXP_W + MAN_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [FLT_W-1:0] op_i,
   input logic             valid_o,
   input logic [OUT_W-1:0] result_o,
   input logic [1:0]       exc_o
);
   logic op_nan;
   logic op_neg;
   logic op_zero;
   assign op_nan  = (&op_i[FLT_W-2 -: EXP_W]) && (|op_i[MAN_W-1:0]);
   assign op_neg  = op_i[FLT_W-1] && (|op_i[FLT_W-2:0]);
   assign op_zero = ~|op_i[FLT_W-2:0];

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !valid_o);
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(result_o) && $stable(exc_o)));
   a_r3_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_nan) |=> (result_o == '0 && exc_o == 2'b01));
   a_r4_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_neg) |=> (result_o == '0 && exc_o == 2'b01));
   a_r5_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_zero) |=> (result_o == '0 && exc_o == 2'b00));
   a_r6_sat_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && (&result_o)) |-> (exc_o == 2'b01));
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (exc_o != 2'b11));
endmodule

bind flt2uns_trunc flt2uns_trunc_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .op_i     (op_i),
   .valid_o  (valid_o),
   .result_o (result_o),
   .exc_o    (exc_o)
);

// File: tb/sim_flt2uns_trunc.sv
module sim_flt2uns_trunc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] op_i = '0;
   logic        valid_o;
   logic [31:0] result_o;
   logic [1:0]  exc_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   flt2uns_trunc u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .valid_o(valid_o), .result_o(result_o), .exc_o(exc_o)
   );

   task automatic model(input logic [31:0] v, output logic [31:0] r,
                        output logic [1:0] e, output string tag);
      int ue;
      longint unsigned sig;
      logic [7:0] ex;
      ex = v[30:23];
      r = '0; e = 2'b00;
      if (ex == 8'hFF && v[22:0] != 0) begin e = 2'b01; tag = "R3"; end
      else if (v[31] && v[30:0] != 0) begin e = 2'b01; tag = "R4"; end
      else if (v[30:0] == 0) begin tag = "R5"; end
      else if (ex == 8'hFF) begin r = '1; e = 2'b01; tag = "R6"; end
      else if (ex == 0) begin e = 2'b10; tag = "R8"; end
      else begin
         ue = int'(ex) - 127;
         if (ue < 0) begin e = 2'b10; tag = "R8"; end
         else if (ue >= 32) begin r = '1; e = 2'b01; tag = "R6"; end
         else begin
            sig = 64'h80_0000 + 64'(v[22:0]);
            tag = "R7";
            if (ue >= 23) r = 32'(sig << (ue - 23));
            else begin
               r = 32'(sig >> (23 - ue));
               if ((sig % (64'd1 << (23 - ue))) != 0) e = 2'b10;
            end
         end
      end
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s op=%h actual=%h expected=%h", tag, what, op_i, act, exp);
      end
   endtask

   task automatic run_one(input logic [31:0] v);
      logic [31:0] r;
      logic [1:0]  e;
      string       tag;
      @(negedge clk);
      op_i = v;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      model(v, r, e, tag);
      check("R1", "valid", 32'(valid_o), 32'd1);
      check(tag, "result", result_o, r);
      check(tag == "R3" || tag == "R4" || tag == "R6" ? tag : "R9", "exc",
            32'(exc_o), 32'(e));
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [22:0] pats [6];
      logic [31:0] keep_r;
      logic [1:0]  keep_e;
      pats[0] = 23'h000000; pats[1] = 23'h000001; pats[2] = 23'h400000;
      pats[3] = 23'h7FFFFF; pats[4] = 23'h2AAAAA; pats[5] = 23'h155555;

      // R2: reset state
      #12;
      check("R2", "valid", 32'(valid_o), 32'd0);
      check("R2", "result", result_o, 32'd0);
      check("R2", "exc", 32'(exc_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      run_one(32'hBF000000);   // R4: -0.5
      run_one(32'h80000000);   // R5: -0.0
      run_one(32'h00000000);   // R5: +0.0
      run_one(32'h4F800000);   // R6: 2^32
      run_one(32'h7F800000);   // R6: +inf
      run_one(32'hFF800000);   // R4: -inf
      run_one(32'h7FC00000);   // R3: quiet NaN
      run_one(32'h7F800001);   // R3: signaling NaN
      run_one(32'h4F7FFFFF);   // R7: 0xFFFFFF00 exact
      run_one(32'h40490FDB);   // R7: pi -> 3 inexact
      run_one(32'h3F800000);   // R7: 1.0 exact
      run_one(32'h3F7FFFFF);   // R8: just below 1.0
      run_one(32'h00000001);   // R8: smallest denormal
      run_one(32'h80000001);   // R4: negative denormal

      // R1: hold while idle
      keep_r = result_o;
      keep_e = exc_o;
      op_i = 32'h4B000007;
      @(negedge clk);
      @(negedge clk);
      check("R1", "idle valid", 32'(valid_o), 32'd0);
      check("R1", "hold result", result_o, keep_r);
      check("R1", "hold exc", 32'(keep_e), 32'(exc_o));

      // R1: back-to-back starts
      @(negedge clk);
      op_i = 32'h41200000;  // 10.0
      start_i = 1'b1;
      @(negedge clk);
      op_i = 32'h42C80000;  // 100.0
      check("R1", "b2b valid first", 32'(valid_o), 32'd1);
      check("R7", "b2b result first", result_o, 32'd10);
      @(negedge clk);
      start_i = 1'b0;
      check("R1", "b2b valid second", 32'(valid_o), 32'd1);
      check("R7", "b2b result second", result_o, 32'd100);
      @(negedge clk);
      check("R1", "valid drop", 32'(valid_o), 32'd0);

      // sweep: both signs, every exponent, fraction patterns
      for (int s = 0; s < 2; s++)
         for (int ex = 0; ex < 256; ex++)
            for (int p = 0; p < 6; p++)
               run_one({1'(s), 8'(ex), pats[p]});

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule